// File: doc/BRIEF.md
# Line-Synchronous Scan-Out Start Address

This block keeps the frame start address for a raster scan-out engine and gives the memory address of the scanline now being fetched. Software writes the start address through a small register port in three pieces: a low byte, a middle byte and a narrow extension field that carries the top bits. The low and middle pieces are only staged. A write to the extension field takes a snapshot of the whole three-piece value and arms it. The live address takes that value on the next horizontal-blank strobe, so a page flip can land on any line boundary and never partway through a line.

An external timing generator supplies one-cycle horizontal-blank and vertical-blank start strobes and a line-active level. From these the block keeps a line index within the frame and a vertical-retrace status bit. It also holds a sticky frame interrupt flag with an enable, so software can put its updates between frames. The line address is the live start address plus the line index times a programmable pitch.

Top module: `raster_start_addr`

## Requirements
- R1: After reset the live start address, the arm flag, the line index, the vertical-retrace bit, the interrupt flag, the interrupt enable and the interrupt output are all zero.
- R2: Writes to select 0 (low byte) or select 1 (middle byte) never change the live start address or the arm flag. A horizontal-blank strobe while nothing is armed leaves the live address unchanged.
- R3: A write to select 2 (extension, data bits EXT_W-1:0) sets the arm flag on the next cycle, and the live address does not change until a horizontal-blank strobe.
- R4: On a horizontal-blank strobe while armed, the live address becomes {extension, middle, low} as captured at the extension write, and the arm flag clears.
- R5: When the extension is written more than once before a horizontal-blank strobe, the value captured by the most recent extension write becomes live.
- R6: Low or middle writes made after the extension write and before the switch do not alter the armed value.
- R7: The line address output equals the live start address plus the line index times the pitch input, truncated to the address width.
- R8: The line index clears on a vertical-blank strobe and increments, modulo 2^LINE_W, on a horizontal-blank strobe while line-active is high. A horizontal-blank strobe with line-active low does not change it.
- R9: After a switch at the end of line k, the next line's address is the new start address plus (k+1) times the pitch.
- R10: The vertical-retrace bit sets on a vertical-blank strobe and clears once line-active is high.
- R11: The interrupt flag sets on a vertical-blank strobe and clears when 1 is written to bit 0 of select 4. Writing 0 there leaves it set, and a set in the same cycle as a clear wins.
- R12: The interrupt output is high only while the flag is set and the enable (bit 0 of select 3) is 1.
- R13: Writes to selects 5, 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select: 0 low, 1 middle, 2 extension, 3 enable, 4 flag clear |
| regWdata | input | DATA_W | Write data |
| linePitch | input | PITCH_W | Address distance between consecutive lines |
| hblankStart | input | 1 | One-cycle strobe at horizontal-blank start |
| vblankStart | input | 1 | One-cycle strobe at vertical-blank start |
| lineActive | input | 1 | High while a visible line is being scanned |
| liveStart | output | ADDR_W | Start address in use |
| armed | output | 1 | A new start address waits for the next horizontal blank |
| lineAddr | output | ADDR_W | Fetch address of the current line |
| lineCount | output | LINE_W | Line index within the frame |
| vRetrace | output | 1 | Vertical-retrace status |
| irqPending | output | 1 | Sticky frame interrupt flag |
| irq | output | 1 | Gated interrupt output |

## Verification
The bench builds the block with 8-bit data, a 4-bit extension (20-bit address), a 10-bit pitch and a 4-bit line index. The narrow line index lets a short run wrap the counter, and the 20-bit address keeps the sum of start address and line offset checkable. With these sizes, same-cycle collisions (vertical blank against flag clear, repeated extension writes, a mid-frame switch after several lines) take only a few dozen cycles.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  typedef struct packed {
    logic wrLow;
    logic wrMid;
    logic wrExt;
    logic swap;
    logic lineClr;
    logic lineInc;
  } dpStrobe_t;

  localparam logic [2:0] SEL_LOW  = 3'd0;
  localparam logic [2:0] SEL_MID  = 3'd1;
  localparam logic [2:0] SEL_EXT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;
endpackage

// File: rtl/scan_addr_ctrl.sv
module scan_addr_ctrl
  import scan_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [2:0] regSel,
  input  logic       wdataBit0,
  input  logic       hblankStart,
  input  logic       vblankStart,
  input  logic       lineActive,
  output dpStrobe_t  st,
  output logic       armed,
  output logic       vRetrace,
  output logic       irqPending,
  output logic       irq
);
  logic irqEn;
  logic extWr;
  logic flagClr;

  assign extWr   = regWr && (regSel == SEL_EXT);
  assign flagClr = regWr && (regSel == SEL_STAT) && wdataBit0;

  always_comb begin
    st.wrLow   = regWr && (regSel == SEL_LOW);
    st.wrMid   = regWr && (regSel == SEL_MID);
    st.wrExt   = extWr;
    st.swap    = hblankStart && armed;
    st.lineClr = vblankStart;
    st.lineInc = hblankStart && lineActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      vRetrace   <= 1'b0;
      irqPending <= 1'b0;
      irqEn      <= 1'b0;
    end else begin
      if (extWr)                  armed <= 1'b1;
      else if (hblankStart)       armed <= 1'b0;

      if (vblankStart)            vRetrace <= 1'b1;
      else if (lineActive)        vRetrace <= 1'b0;

      if (vblankStart)            irqPending <= 1'b1;
      else if (flagClr)           irqPending <= 1'b0;

      if (regWr && regSel == SEL_CTRL) irqEn <= wdataBit0;
    end
  end

  assign irq = irqPending && irqEn;

  // R3
  ext_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == SEL_EXT) |=> armed);

  // R4
  swap_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hblankStart && armed && !(regWr && regSel == SEL_EXT)) |=> !armed);

  // R10
  vbl_retrace_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> vRetrace);

  // R11
  vbl_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> irqPending);

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqPending);
endmodule

// File: rtl/scan_addr_datapath.sv
module scan_addr_datapath
  import scan_addr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_W   = 4,
  parameter int LINE_W  = 11,
  parameter int PITCH_W = 12,
  localparam int ADDR_W = 2 * DATA_W + EXT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          st,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [PITCH_W-1:0] linePitch,
  output logic [ADDR_W-1:0]  liveStart,
  output logic [ADDR_W-1:0]  lineAddr,
  output logic [LINE_W-1:0]  lineCount
);
  logic [DATA_W-1:0] lowReg;
  logic [DATA_W-1:0] midReg;
  logic [ADDR_W-1:0] pendStart;
  logic [ADDR_W-1:0] lineOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg    <= '0;
      midReg    <= '0;
      pendStart <= '0;
      liveStart <= '0;
      lineCount <= '0;
    end else begin
      if (st.wrLow) lowReg <= regWdata;
      if (st.wrMid) midReg <= regWdata;
      if (st.swap)  liveStart <= pendStart;
      if (st.wrExt) pendStart <= {regWdata[EXT_W-1:0], midReg, lowReg};
      if (st.lineClr)      lineCount <= '0;
      else if (st.lineInc) lineCount <= lineCount + 1'b1;
    end
  end

  assign lineOffset = ADDR_W'(lineCount) * ADDR_W'(linePitch);
  assign lineAddr   = liveStart + lineOffset;

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.swap |=> $stable(liveStart));

  // R8
  line_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.lineClr |=> (lineCount == '0));

  // R8
  line_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.lineInc && !st.lineClr) |=> (lineCount == LINE_W'($past(lineCount) + 1'b1)));
endmodule

// File: rtl/raster_start_addr.sv
module raster_start_addr
  import scan_addr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_W   = 4,
  parameter int LINE_W  = 11,
  parameter int PITCH_W = 12,
  localparam int ADDR_W = 2 * DATA_W + EXT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [PITCH_W-1:0] linePitch,
  input  logic               hblankStart,
  input  logic               vblankStart,
  input  logic               lineActive,
  output logic [ADDR_W-1:0]  liveStart,
  output logic               armed,
  output logic [ADDR_W-1:0]  lineAddr,
  output logic [LINE_W-1:0]  lineCount,
  output logic               vRetrace,
  output logic               irqPending,
  output logic               irq
);
  dpStrobe_t st;

  scan_addr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .wdataBit0(regWdata[0]), .hblankStart(hblankStart),
    .vblankStart(vblankStart), .lineActive(lineActive), .st(st),
    .armed(armed), .vRetrace(vRetrace), .irqPending(irqPending), .irq(irq)
  );

  scan_addr_datapath #(
    .DATA_W(DATA_W), .EXT_W(EXT_W), .LINE_W(LINE_W), .PITCH_W(PITCH_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .regWdata(regWdata),
    .linePitch(linePitch), .liveStart(liveStart), .lineAddr(lineAddr),
    .lineCount(lineCount)
  );
endmodule

// File: tb/sim_raster_start_addr.sv
module sim_raster_start_addr;
  localparam int DATA_W = 8, EXT_W = 4, LINE_W = 4, PITCH_W = 10;
  localparam int ADDR_W = 2 * DATA_W + EXT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regSel = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [PITCH_W-1:0] linePitch = 10'h040;
  logic hblankStart = 1'b0, vblankStart = 1'b0, lineActive = 1'b0;
  logic [ADDR_W-1:0] liveStart, lineAddr;
  logic armed, vRetrace, irqPending, irq;
  logic [LINE_W-1:0] lineCount;

  always #2.5 clk = ~clk;

  raster_start_addr #(.DATA_W(DATA_W), .EXT_W(EXT_W), .LINE_W(LINE_W), .PITCH_W(PITCH_W)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .linePitch(linePitch), .hblankStart(hblankStart), .vblankStart(vblankStart),
    .lineActive(lineActive), .liveStart(liveStart), .armed(armed), .lineAddr(lineAddr),
    .lineCount(lineCount), .vRetrace(vRetrace), .irqPending(irqPending), .irq(irq)
  );

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [DATA_W-1:0] mLow = '0, mMid = '0;
  logic [ADDR_W-1:0] mPend = '0, mLive = '0;
  logic mArm = 0, mVr = 0, mFlag = 0, mEn = 0;
  logic [LINE_W-1:0] mLine = '0;

  function automatic logic [31:0] actual(int kind);
    case (kind)
      0: return 32'(liveStart);
      1: return 32'(armed);
      2: return 32'(lineAddr);
      3: return 32'(lineCount);
      4: return 32'(vRetrace);
      5: return 32'(irqPending);
      default: return 32'(irq);
    endcase
  endfunction

  task automatic pushAll(string req);
    logic [ADDR_W-1:0] ea;
    ea = mLive + ADDR_W'(mLine) * ADDR_W'(linePitch);
    q.push_back('{0, 32'(mLive), req});
    q.push_back('{1, 32'(mArm), req});
    q.push_back('{2, 32'(ea), req});
    q.push_back('{3, 32'(mLine), req});
    q.push_back('{4, 32'(mVr), req});
    q.push_back('{5, 32'(mFlag), req});
    q.push_back('{6, 32'(mFlag && mEn), req});
  endtask

  // driver: one stimulus cycle, model the edge, queue expectations
  task automatic cyc(input bit wr, input logic [2:0] sel, input logic [7:0] d,
                     input bit hb, input bit vb, input bit la, input string req);
    bit swap;
    @(negedge clk);
    regWr = wr; regSel = sel; regWdata = d;
    hblankStart = hb; vblankStart = vb; lineActive = la;
    swap = hb && mArm;
    if (swap) mLive = mPend;
    if (wr && sel == 3'd2) begin
      mPend = {d[EXT_W-1:0], mMid, mLow};
      mArm = 1;
    end else if (swap) mArm = 0;
    if (wr && sel == 3'd0) mLow = d;
    if (wr && sel == 3'd1) mMid = d;
    if (vb) mLine = '0; else if (hb && la) mLine = mLine + 1'b1;
    if (vb) mVr = 1; else if (la) mVr = 0;
    if (vb) mFlag = 1; else if (wr && sel == 3'd4 && d[0]) mFlag = 0;
    if (wr && sel == 3'd3) mEn = d[0];
    pushAll(req);
    @(posedge clk); #2;
    regWr = 0; hblankStart = 0; vblankStart = 0;
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      a = actual(it.kind);
      checks++;
      if (a !== it.exp) begin
        fails++;
        $display("FAIL %s output %0d: actual %h expected %h", it.req, it.kind, a, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    cyc(0, 0, 0, 0, 0, 1, "R1");
    // staging writes and idle hblank
    cyc(1, 0, 8'h34, 0, 0, 1, "R2");
    cyc(1, 1, 8'h12, 0, 0, 1, "R2");
    cyc(0, 0, 0, 1, 0, 1, "R2");
    // arm, then late low write, then switch
    cyc(1, 2, 8'h05, 0, 0, 1, "R3");
    cyc(0, 0, 0, 0, 0, 1, "R3");
    cyc(1, 0, 8'hFF, 0, 0, 1, "R6");
    cyc(0, 0, 0, 1, 0, 1, "R4");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    // repeated extension writes
    cyc(1, 1, 8'hAB, 0, 0, 1, "R5");
    cyc(1, 2, 8'h02, 0, 0, 1, "R5");
    cyc(1, 2, 8'h03, 0, 0, 1, "R5");
    cyc(0, 0, 0, 1, 0, 1, "R5");
    // frame boundary and interrupt
    cyc(0, 0, 0, 0, 1, 0, "R10");
    cyc(1, 3, 8'h01, 0, 0, 0, "R12");
    cyc(1, 4, 8'h00, 0, 0, 0, "R11");
    cyc(1, 4, 8'h01, 0, 0, 0, "R11");
    cyc(1, 4, 8'h01, 0, 1, 0, "R11");
    cyc(1, 4, 8'h01, 0, 0, 0, "R11");
    cyc(1, 3, 8'h00, 0, 1, 0, "R12");
    cyc(0, 0, 0, 0, 0, 1, "R10");
    // mid-frame switch after three lines
    cyc(0, 0, 0, 1, 0, 1, "R8");
    cyc(0, 0, 0, 1, 0, 1, "R8");
    cyc(0, 0, 0, 1, 0, 1, "R8");
    cyc(1, 0, 8'h00, 0, 0, 1, "R9");
    cyc(1, 1, 8'h10, 0, 0, 1, "R9");
    cyc(1, 2, 8'h01, 0, 0, 1, "R9");
    cyc(0, 0, 0, 1, 0, 1, "R9");
    // unused selects
    cyc(1, 5, 8'hFF, 0, 0, 1, "R13");
    cyc(1, 6, 8'hFF, 0, 0, 1, "R13");
    cyc(1, 7, 8'hFF, 0, 0, 1, "R13");
    // hblank outside active line, then wrap
    cyc(0, 0, 0, 1, 0, 0, "R8");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule